// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block is the digital control logic of a six-bit step attenuator whose least significant step is 0.5 dB. It produces the six-bit attenuation word that drives the switched array. The word comes either from a serial interface or from six parallel control lines. A mode select input chooses between the two. All control inputs are treated as asynchronous. They are brought into the system clock domain through a synchronizer, and edges of the serial clock and of the load strobe are detected there.

In serial operation, bits are shifted into a six-bit register on rising edges of the serial clock, with the most significant bit first. A transparent latch sits behind the register and is controlled by the load strobe: while the strobe is high, the register drives the output, and when the strobe goes low, the output holds. In parallel operation, the same strobe either passes the six lines straight through (strobe tied high) or captures them during a high pulse and keeps them afterwards.

When reset is released, the block waits until the synchronizer holds valid input values. It then loads a start-up word once and switches to normal operation. The source of the start-up word depends on the mode and on the strobe level: the parallel lines, or a fixed word picked by two preset pins.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `rst_n` is low, `atten_word` is 0.
- R2: At start-up in parallel mode (`mode_sel`=0) with `load_en` low, `preset_sel` picks the word: 2'b00 gives 0x00 (0 dB), 2'b01 gives 0x10 (8 dB), 2'b10 gives 0x20 (16 dB), 2'b11 gives 0x3F (31.5 dB).
- R3: At start-up in parallel mode with `load_en` high, `preset_sel` is ignored and `atten_word` takes `par_word`.
- R4: At start-up in serial mode (`mode_sel`=1), `atten_word` takes `par_word`, whatever the levels of `load_en` and `preset_sel`.
- R5: In serial mode, each rising edge of `ser_clk` shifts `ser_dat` into bit 0 of the serial register, and the older bits move up one place. After six edges, the first bit sent sits in bit 5, which is the 16 dB weight. Bit 0 is the 0.5 dB weight. The weights of bits 4 to 1 are 8, 4, 2 and 1 dB.
- R6: In serial mode with `load_en` high, `atten_word` follows the serial register, including shifts made while the strobe is high.
- R7: While `load_en` is low after start-up, `atten_word` holds its value in both modes, and through mode changes and input changes.
- R8: In parallel mode with `load_en` high, `atten_word` follows `par_word`. This is direct operation when the strobe stays high, and latched capture when the strobe is pulsed.
- R9: In parallel mode, `ser_dat` and `ser_clk` have no effect: the serial register keeps its contents.
- R10: The start-up word is applied exactly once, SYNC_STAGES+2 clock cycles after reset release. Until then `atten_word` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; releasing it starts the start-up sequence |
| mode_sel | input | 1 | Interface select: 0 parallel, 1 serial |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_clk | input | 1 | Serial shift clock, sampled for rising edges |
| load_en | input | 1 | Load strobe: high means transparent, low means hold |
| par_word | input | 6 | Parallel control lines, bit 0 = 0.5 dB ... bit 5 = 16 dB |
| preset_sel | input | 2 | Start-up preset choice in parallel mode |
| atten_word | output | 6 | Attenuation word to the switched array |

## Verification
The embedded properties check, on every cycle, several local rules. The output holds while the synchronized strobe is low. The output follows the serial register, or the parallel lines, one cycle after the strobe is seen high. The serial register shifts only on a detected clock edge in serial mode. The start-up word is applied once, stays within the four preset codes when those are used, and the output stays zero before it. Some behaviour is only visible across the input pins, and only the bench scenarios can show it. These cover the bit order and the weight mapping of a complete serial word, the preset table for each code, and the fact that the serial register survives toggling in parallel mode and appears again on return to serial. They also cover latched and direct parallel sequences as seen through the synchronizer delay.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int WORD_W = 6;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } if_mode_e;

    // bit positions of the two weights used by the presets
    localparam int POS_8DB  = 4;
    localparam int POS_16DB = 5;

    typedef logic [WORD_W-1:0] atten_word_t;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic             rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic                         prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
    assign rise_o = st_q.chain[STAGES-1][0] & ~st_q.prev;
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter
    import atten_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        shift_en,
    input  logic        din,
    output atten_word_t shreg_o
);
    atten_word_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) sh_d = {sh_q[WORD_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign shreg_o = sh_q;

    // R5
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sh_q == {$past(sh_q[WORD_W-2:0]), $past(din)});
    // R9
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/atten_preset.sv
module atten_preset
    import atten_pkg::*;
(
    input  if_mode_e    mode,
    input  logic        load_en,
    input  atten_word_t par_word,
    input  logic [1:0]  preset_sel,
    output atten_word_t boot_word
);
    atten_word_t table_word;

    always_comb begin
        table_word = '0;
        unique case (preset_sel)
            2'b00: table_word = '0;
            2'b01: table_word[POS_8DB] = 1'b1;
            2'b10: table_word[POS_16DB] = 1'b1;
            default: table_word = '1;
        endcase
    end

    always_comb begin
        if (mode == MODE_SER || load_en) boot_word = par_word;
        else                             boot_word = table_word;
    end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              ser_dat,
    input  logic              ser_clk,
    input  logic              load_en,
    input  logic [WORD_W-1:0] par_word,
    input  logic [1:0]        preset_sel,
    output logic [WORD_W-1:0] atten_word
);
    localparam int IN_W      = 4 + WORD_W + 2;
    localparam int BOOT_WAIT = SYNC_STAGES + 1;
    localparam int CNT_W     = $clog2(BOOT_WAIT + 1);

    logic [IN_W-1:0] raw_in, sync_in;
    logic            clk_rise;

    assign raw_in = {preset_sel, par_word, mode_sel, load_en, ser_dat, ser_clk};

    atten_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (sync_in),
        .rise_o (clk_rise)
    );

    logic        dat_s, le_s;
    if_mode_e    mode_s;
    atten_word_t par_s;
    logic [1:0]  pre_s;

    assign dat_s  = sync_in[1];
    assign le_s   = sync_in[2];
    assign mode_s = if_mode_e'(sync_in[3]);
    assign par_s  = sync_in[4 +: WORD_W];
    assign pre_s  = sync_in[4 + WORD_W +: 2];

    typedef struct packed {
        atten_word_t      out;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_st_t;

    ctrl_st_t    st_d, st_q;
    atten_word_t shreg, boot_word;
    logic        boot_fire;

    atten_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(clk_rise && mode_s == MODE_SER && st_q.done),
        .din     (dat_s),
        .shreg_o (shreg)
    );

    atten_preset u_preset (
        .mode      (mode_s),
        .load_en   (le_s),
        .par_word  (par_s),
        .preset_sel(pre_s),
        .boot_word (boot_word)
    );

    assign boot_fire = !st_q.done && (st_q.cnt == CNT_W'(BOOT_WAIT));

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            if (boot_fire) begin
                st_d.done = 1'b1;
                st_d.out  = boot_word;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (le_s) begin
            st_d.out = (mode_s == MODE_SER) ? shreg : par_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign atten_word = st_q.out;

    // R7
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !le_s |=> $stable(atten_word));
    // R6
    ser_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && le_s && mode_s == MODE_SER |=> atten_word == $past(shreg));
    // R8
    par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && le_s && mode_s == MODE_PAR |=> atten_word == $past(par_s));
    // R2
    preset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_fire && !le_s && mode_s == MODE_PAR |=>
            (atten_word == 6'h00 || atten_word == 6'h10 ||
             atten_word == 6'h20 || atten_word == 6'h3F));
    // R10
    boot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done && !boot_fire);
    // R10
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done && !boot_fire |=> atten_word == '0);
endmodule

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       mode_sel = 0, ser_dat = 0, ser_clk = 0, load_en = 0;
    logic [5:0] par_word = 0;
    logic [1:0] preset_sel = 0;
    logic [5:0] atten_word;

    int checks = 0, errors = 0;
    bit finished = 0;

    typedef struct { logic [5:0] w; string tag; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    step_atten_ctrl i_step_atten_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ser_dat(ser_dat),
        .ser_clk(ser_clk), .load_en(load_en), .par_word(par_word),
        .preset_sel(preset_sel), .atten_word(atten_word)
    );

    // monitor: compare queued expectations at the following falling edge
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (atten_word !== e.w) begin
                errors++;
                $display("FAIL %s: got %h expected %h", e.tag, atten_word, e.w);
            end
        end
    end

    task automatic expect_word(input logic [5:0] w, input string tag);
        repeat (6) @(negedge clk);
        exp_q.push_back('{w, tag});
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset(input logic m, input logic le,
                            input logic [5:0] p, input logic [1:0] pre);
        @(negedge clk);
        rst_n = 0; mode_sel = m; load_en = le; par_word = p; preset_sel = pre;
        ser_clk = 0; ser_dat = 0;
        expect_word(6'h00, "R1 reset value");
        rst_n = 1;
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1;
        repeat (3) @(negedge clk);
        ser_clk = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic shift_word(input logic [5:0] w);
        for (int i = 5; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_le();
        load_en = 1;
        repeat (5) @(negedge clk);
        load_en = 0;
    endtask

    initial begin
        // R2: start-up preset table, parallel mode, strobe low
        do_reset(0, 0, 6'h15, 2'b00); expect_word(6'h00, "R2 preset 00");
        do_reset(0, 0, 6'h15, 2'b01); expect_word(6'h10, "R2 preset 01");
        do_reset(0, 0, 6'h15, 2'b10); expect_word(6'h20, "R2 preset 10");
        do_reset(0, 0, 6'h15, 2'b11); expect_word(6'h3F, "R2 preset 11");
        // R3: parallel, strobe high: presets ignored
        do_reset(0, 1, 6'h15, 2'b11); expect_word(6'h15, "R3 boot from lines");
        // R10: boot timing, zero until SYNC_STAGES+2 cycles after release
        @(negedge clk);
        rst_n = 0; mode_sel = 0; load_en = 0; preset_sel = 2'b11;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        exp_q.push_back('{6'h00, "R10 before boot"});
        @(negedge clk);
        @(negedge clk);
        exp_q.push_back('{6'h3F, "R10 boot applied"});
        repeat (2) @(negedge clk);
        // R4: serial boot from parallel lines
        do_reset(1, 0, 6'h2A, 2'b01); expect_word(6'h2A, "R4 serial boot");
        // R7: shift with strobe low, output holds
        shift_word(6'h13);
        expect_word(6'h2A, "R7 serial hold");
        // R5: strobe pulse latches full word, MSB first
        pulse_le();
        expect_word(6'h13, "R5 serial word");
        shift_word(6'h3C);
        expect_word(6'h13, "R7 serial hold 2");
        // R6: transparent with strobe high, follows a shift
        load_en = 1;
        expect_word(6'h3C, "R6 transparent");
        shift_bit(1);
        expect_word(6'h39, "R6 follows shift");
        load_en = 0;
        repeat (4) @(negedge clk);
        // R7: change to parallel with strobe low
        mode_sel = 0; par_word = 6'h07;
        expect_word(6'h39, "R7 mode change hold");
        // R8: latched parallel
        pulse_le();
        expect_word(6'h07, "R8 latched capture");
        par_word = 6'h30;
        expect_word(6'h07, "R7 parallel hold");
        // R8: direct parallel
        load_en = 1;
        expect_word(6'h30, "R8 direct");
        par_word = 6'h3F;
        expect_word(6'h3F, "R8 direct 31.5 dB");
        // R9: serial pins ignored in parallel mode
        shift_word(6'h00);
        expect_word(6'h3F, "R9 pins ignored");
        mode_sel = 1;
        expect_word(6'h39, "R9 register kept");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule